// File: doc/BRIEF.md
# Two-Slot In-Order Issue Stage

This block sits between instruction fetch and the execution units of a small superscalar pipeline. It keeps two decoded instructions in an ordered pair of slots, slot 0 being the older. Each cycle an outside circuit looks at the slot contents and tells the block, per slot, whether that instruction could go now, folding together operand readiness and unit availability. The block then decides what actually issues. The rule is that nothing overtakes an older instruction. If only the older one leaves, the younger moves up into slot 0. Empty slots are filled from fetch in program order.

Issued branches are also copied into a one-entry branch holding station. There a branch waits for its condition while younger non-branch work keeps flowing. A second branch cannot issue while the station is occupied, unless the station is being released in that same cycle. A flush empties the slots and the station at once.

Top module: `iss_pair_stage`

## Requirements
- R1: While reset is high and on the first cycle after it, both slots are empty (slot_valid = 0), iss_strobe = 0, br_busy = 0 and fetch_room = 2.
- R2: Instructions leave the block in exactly the order fetch delivered them. iss_strobe = 2'b10 (slot 1 without slot 0) never occurs.
- R3: If slot 0 holds an instruction whose can-issue bit is low, nothing issues that cycle, whatever slot 1's bit is, and both slots keep their contents.
- R4: If slot 0 issues and slot 1 does not, then on the next cycle iss_strobe = 2'b01 and iss_data0 carries the old slot 0 payload. In that same cycle slot 0 holds the former slot 1 instruction.
- R5: Both slots issue in one cycle only when both can-issue bits are high and neither is held back by the branch rule. The next cycle shows iss_strobe = 2'b11, with iss_data0 carrying the older payload and iss_data1 the younger.
- R6: An empty slot never issues, even when its can-issue bit is high.
- R7: Each cycle the block accepts min(fetch_count, fetch_room) instructions from fetch, where a fetch_count of 3 counts as 2. Item 0 is older than item 1. Accepted items go behind the instructions that remain, lowest free slot first. Items beyond that number are dropped.
- R8: fetch_room equals the number of empty slots (0, 1 or 2). Slot 1 is never valid while slot 0 is empty.
- R9: A branch that issues (slot_br bit = 1) is held in the station on the next cycle (br_busy = 1, br_data = its payload). It stays there unchanged until a cycle with br_done high. br_done while the station is empty has no effect.
- R10: A branch in a slot issues only if the station is empty or br_done is high in that cycle. At most one branch issues per cycle. Non-branch instructions issue normally while the station is occupied.
- R11: flush high empties both slots and the station on the next cycle. No instruction issues and no fetch item is accepted in the flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard slot and station contents |
| fetch_count | input | 2 | Number of offered fetch items (3 counts as 2) |
| fetch_data0 | input | DATA_W | Older offered instruction |
| fetch_data1 | input | DATA_W | Younger offered instruction |
| fetch_br | input | 2 | Branch flag per offered item |
| fetch_room | output | 2 | Number of empty slots |
| slot_valid | output | 2 | Slot occupancy, bit 0 = older slot |
| slot_br | output | 2 | Branch flag of each slot |
| slot_data0 | output | DATA_W | Payload held in slot 0 |
| slot_data1 | output | DATA_W | Payload held in slot 1 |
| slot_can_issue | input | 2 | External per-slot readiness for the current contents |
| br_done | input | 1 | The held branch has resolved |
| iss_strobe | output | 2 | Registered issue strobes from the previous cycle's decision |
| iss_data0 | output | DATA_W | Payload issued from slot 0 |
| iss_data1 | output | DATA_W | Payload issued from slot 1 |
| br_busy | output | 1 | Branch holding station occupied |
| br_data | output | DATA_W | Payload of the held branch |

## Verification
A wrong shift or refill would put a payload in the wrong slot. That shows on slot_data0/slot_data1 on the very next cycle, and one cycle after that it corrupts the order of payloads on the issue ports, where the in-order scoreboard catches it. A stale valid bit shows at once as a wrong fetch_room, or as a strobe from an empty slot. A station that clears or loads at the wrong time shows on br_busy/br_data one cycle later. It also wrongly admits or blocks the next branch in slot 0.

// File: rtl/iss_pkg.sv
package iss_pkg;
  typedef logic [1:0] cnt_t;

  function automatic cnt_t cnt_clamp(cnt_t c);
    return (c == 2'd3) ? 2'd2 : c;
  endfunction

  function automatic cnt_t cnt_min(cnt_t a, cnt_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/iss_arbiter.sv
module iss_arbiter
  import iss_pkg::*;
(
  input  logic [1:0] slot_valid,
  input  logic [1:0] slot_br,
  input  logic [1:0] can_issue,
  input  logic       flush,
  input  logic       st_busy,
  input  logic       st_done,
  output logic [1:0] go,
  output cnt_t       go_n,
  output logic       st_load,
  output logic       st_sel1
);
  logic st_free;
  logic ok0, ok1;

  always_comb begin
    st_free = !st_busy || st_done;
    ok0 = slot_valid[0] && can_issue[0] && (!slot_br[0] || st_free) && !flush;
    ok1 = ok0 && slot_valid[1] && can_issue[1] &&
          (!slot_br[1] || (st_free && !slot_br[0]));
    go      = {ok1, ok0};
    go_n    = {1'b0, ok0} + {1'b0, ok1};
    st_load = (ok0 && slot_br[0]) || (ok1 && slot_br[1]);
    st_sel1 = !(ok0 && slot_br[0]);
  end
endmodule

// File: rtl/iss_slot_queue.sv
module iss_slot_queue
  import iss_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  cnt_t              go_n,
  input  cnt_t              fetch_count,
  input  logic [DATA_W-1:0] fetch_data0,
  input  logic [DATA_W-1:0] fetch_data1,
  input  logic [1:0]        fetch_br,
  output logic [1:0]        slot_valid,
  output logic [1:0]        slot_br,
  output logic [DATA_W-1:0] slot_data0,
  output logic [DATA_W-1:0] slot_data1,
  output cnt_t              room
);
  localparam int NSLOT = 2;

  logic [DATA_W-1:0] d_q [NSLOT];
  logic [DATA_W-1:0] d_n [NSLOT];
  logic [NSLOT-1:0]  v_q, v_n, b_q, b_n;
  logic [DATA_W-1:0] f_d [NSLOT];
  cnt_t occ, acc, rem;

  always_comb begin
    f_d[0] = fetch_data0;
    f_d[1] = fetch_data1;
    occ  = {1'b0, v_q[0]} + {1'b0, v_q[1]};
    room = 2'd2 - occ;
    acc  = cnt_min(cnt_clamp(fetch_count), room);
    rem  = occ - go_n;
    d_n = d_q;
    v_n = v_q;
    b_n = b_q;
    if (go_n == 2'd1) begin
      d_n[0] = d_q[1];
      b_n[0] = b_q[1];
      v_n    = {1'b0, v_q[1]};
    end else if (go_n == 2'd2) begin
      v_n = '0;
    end
    if (rem == 2'd0 && acc != 2'd0) begin
      d_n[0] = f_d[0];
      b_n[0] = fetch_br[0];
      v_n[0] = 1'b1;
      if (acc == 2'd2) begin
        d_n[1] = f_d[1];
        b_n[1] = fetch_br[1];
        v_n[1] = 1'b1;
      end
    end else if (rem == 2'd1 && acc != 2'd0) begin
      d_n[1] = f_d[0];
      b_n[1] = fetch_br[0];
      v_n[1] = 1'b1;
    end
    if (flush) v_n = '0;
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q[i] <= 1'b0;
        b_q[i] <= 1'b0;
        d_q[i] <= '0;
      end else begin
        v_q[i] <= v_n[i];
        b_q[i] <= b_n[i];
        d_q[i] <= d_n[i];
      end
    end
  end

  assign slot_valid = v_q;
  assign slot_br    = b_q;
  assign slot_data0 = d_q[0];
  assign slot_data1 = d_q[1];
endmodule

// File: rtl/iss_branch_station.sv
module iss_branch_station #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              done,
  output logic              busy,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      data <= '0;
    end else if (flush) begin
      busy <= 1'b0;
    end else if (load) begin
      busy <= 1'b1;
      data <= load_data;
    end else if (done) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/iss_pair_stage.sv
module iss_pair_stage
  import iss_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [1:0]        fetch_count,
  input  logic [DATA_W-1:0] fetch_data0,
  input  logic [DATA_W-1:0] fetch_data1,
  input  logic [1:0]        fetch_br,
  output logic [1:0]        fetch_room,
  output logic [1:0]        slot_valid,
  output logic [1:0]        slot_br,
  output logic [DATA_W-1:0] slot_data0,
  output logic [DATA_W-1:0] slot_data1,
  input  logic [1:0]        slot_can_issue,
  input  logic              br_done,
  output logic [1:0]        iss_strobe,
  output logic [DATA_W-1:0] iss_data0,
  output logic [DATA_W-1:0] iss_data1,
  output logic              br_busy,
  output logic [DATA_W-1:0] br_data
);
  logic [1:0] go;
  cnt_t       go_n;
  logic       st_load, st_sel1;

  iss_arbiter u_arb (
    .slot_valid (slot_valid),
    .slot_br    (slot_br),
    .can_issue  (slot_can_issue),
    .flush      (flush),
    .st_busy    (br_busy),
    .st_done    (br_done),
    .go         (go),
    .go_n       (go_n),
    .st_load    (st_load),
    .st_sel1    (st_sel1)
  );

  iss_slot_queue #(.DATA_W(DATA_W)) u_q (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .go_n        (go_n),
    .fetch_count (fetch_count),
    .fetch_data0 (fetch_data0),
    .fetch_data1 (fetch_data1),
    .fetch_br    (fetch_br),
    .slot_valid  (slot_valid),
    .slot_br     (slot_br),
    .slot_data0  (slot_data0),
    .slot_data1  (slot_data1),
    .room        (fetch_room)
  );

  iss_branch_station #(.DATA_W(DATA_W)) u_bst (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .load      (st_load),
    .load_data (st_sel1 ? slot_data1 : slot_data0),
    .done      (br_done),
    .busy      (br_busy),
    .data      (br_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_strobe <= '0;
      iss_data0  <= '0;
      iss_data1  <= '0;
    end else begin
      iss_strobe <= go;
      iss_data0  <= slot_data0;
      iss_data1  <= slot_data1;
    end
  end
endmodule

// File: rtl/iss_pair_chk.sv
module iss_pair_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic [1:0]        fetch_room,
  input logic [1:0]        slot_valid,
  input logic [1:0]        slot_br,
  input logic [DATA_W-1:0] slot_data0,
  input logic [DATA_W-1:0] slot_data1,
  input logic [1:0]        slot_can_issue,
  input logic              br_done,
  input logic [1:0]        iss_strobe,
  input logic [DATA_W-1:0] iss_data0,
  input logic              br_busy,
  input logic [DATA_W-1:0] br_data
);
  a_r2_in_order: assert property (@(posedge clk) disable iff (rst)
    iss_strobe[1] |-> iss_strobe[0]);

  a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (slot_valid[0] && !slot_can_issue[0] && !flush) |=>
    (iss_strobe == 2'b00 && slot_data0 == $past(slot_data0)));

  a_r4_shift_up: assert property (@(posedge clk) disable iff (rst)
    (slot_valid == 2'b11 && slot_can_issue == 2'b01 && !slot_br[0] && !flush) |=>
    (iss_strobe == 2'b01 && iss_data0 == $past(slot_data0) &&
     slot_data0 == $past(slot_data1)));

  a_r6_empty_quiet: assert property (@(posedge clk) disable iff (rst)
    !slot_valid[0] |=> iss_strobe == 2'b00);

  a_r8_room_count: assert property (@(posedge clk) disable iff (rst)
    fetch_room == 2'(2 - $countones(slot_valid)) && (!slot_valid[1] || slot_valid[0]));

  a_r9_station_hold: assert property (@(posedge clk) disable iff (rst)
    (br_busy && !br_done && !flush) |=> (br_busy && $stable(br_data)));

  a_r10_branch_blocked: assert property (@(posedge clk) disable iff (rst)
    (slot_valid[0] && slot_br[0] && br_busy && !br_done) |=> !iss_strobe[0]);

  a_r11_flush_clear: assert property (@(posedge clk) disable iff (rst)
    flush |=> (slot_valid == 2'b00 && iss_strobe == 2'b00 && !br_busy));
endmodule

bind iss_pair_stage iss_pair_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .flush          (flush),
  .fetch_room     (fetch_room),
  .slot_valid     (slot_valid),
  .slot_br        (slot_br),
  .slot_data0     (slot_data0),
  .slot_data1     (slot_data1),
  .slot_can_issue (slot_can_issue),
  .br_done        (br_done),
  .iss_strobe     (iss_strobe),
  .iss_data0      (iss_data0),
  .br_busy        (br_busy),
  .br_data        (br_data)
);

// File: tb/iss_pair_stage_tb.sv
module iss_pair_stage_tb;
  localparam int DW = 32;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush = 1'b0;
  logic [1:0]    fetch_count = '0;
  logic [DW-1:0] fetch_data0 = '0;
  logic [DW-1:0] fetch_data1 = '0;
  logic [1:0]    fetch_br = '0;
  logic [1:0]    fetch_room;
  logic [1:0]    slot_valid, slot_br;
  logic [DW-1:0] slot_data0, slot_data1;
  logic [1:0]    slot_can_issue = '0;
  logic          br_done = 1'b0;
  logic [1:0]    iss_strobe;
  logic [DW-1:0] iss_data0, iss_data1;
  logic          br_busy;
  logic [DW-1:0] br_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  iss_pair_stage #(.DATA_W(DW)) u_dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(logic [DW-1:0] d);
    exp_q.push_back(d);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    fetch_count = 2'd0;
    flush = 1'b0;
    br_done = 1'b0;
  endtask

  task automatic fetch(logic [1:0] n, logic [DW-1:0] a, logic [DW-1:0] b, logic [1:0] br);
    fetch_count = n;
    fetch_data0 = a;
    fetch_data1 = b;
    fetch_br = br;
  endtask

  // R2 scoreboard: issued payloads must match fetch order
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 2; i++) begin
        if (iss_strobe[i]) begin
          logic [DW-1:0] got;
          got = (i == 0) ? iss_data0 : iss_data1;
          checks++;
          if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R2 actual=%0h expected=none", got);
          end else begin
            logic [DW-1:0] want;
            want = exp_q.pop_front();
            if (got !== want) begin
              failures++;
              $display("FAIL R2 actual=%0h expected=%0h", got, want);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid", slot_valid, 2'b00);
    chk("R1 strobe", iss_strobe, 2'b00);
    chk("R1 room", fetch_room, 2'd2);
    chk("R1 busy", br_busy, 1'b0);
    rst = 1'b0;

    // R7 two-item fill
    fetch(2'd2, 32'hA, 32'hB, 2'b00); push(32'hA); push(32'hB);
    slot_can_issue = 2'b00;
    step();
    chk("R7 valid", slot_valid, 2'b11);
    chk("R7 s0", slot_data0, 32'hA);
    chk("R7 s1", slot_data1, 32'hB);
    chk("R8 room0", fetch_room, 2'd0);

    // R3 slot 0 stalled, slot 1 ready
    slot_can_issue = 2'b10;
    step();
    chk("R3 strobe", iss_strobe, 2'b00);
    chk("R3 s0", slot_data0, 32'hA);
    chk("R3 s1", slot_data1, 32'hB);

    // R4 single issue shifts
    slot_can_issue = 2'b01;
    step();
    chk("R4 strobe", iss_strobe, 2'b01);
    chk("R4 data", iss_data0, 32'hA);
    chk("R4 s0", slot_data0, 32'hB);
    chk("R4 valid", slot_valid, 2'b01);
    chk("R8 room1", fetch_room, 2'd1);

    // R7 room 1, two offered: only C taken
    slot_can_issue = 2'b00;
    fetch(2'd2, 32'hC, 32'hD, 2'b00); push(32'hC);
    step();
    chk("R7 s1", slot_data1, 32'hC);
    chk("R7 valid2", slot_valid, 2'b11);

    // R5 dual issue
    slot_can_issue = 2'b11;
    step();
    chk("R5 strobe", iss_strobe, 2'b11);
    chk("R5 d0", iss_data0, 32'hB);
    chk("R5 d1", iss_data1, 32'hC);
    chk("R8 room2", fetch_room, 2'd2);

    // R6 empty slots with ready high
    step();
    chk("R6 strobe", iss_strobe, 2'b00);

    // R7 single fill, then refill while issuing
    slot_can_issue = 2'b00;
    fetch(2'd1, 32'hE, 32'h0, 2'b00); push(32'hE);
    step();
    chk("R7 s0E", slot_data0, 32'hE);
    slot_can_issue = 2'b01;
    fetch(2'd1, 32'hF, 32'h0, 2'b00); push(32'hF);
    step();
    chk("R7 s0F", slot_data0, 32'hF);
    chk("R7 validF", slot_valid, 2'b01);

    // R9 branch issue captured
    slot_can_issue = 2'b00;
    fetch(2'd1, 32'h6, 32'h0, 2'b01); push(32'h6);
    step();
    slot_can_issue = 2'b11;
    step();
    chk("R9 strobe", iss_strobe, 2'b11);
    chk("R9 busy", br_busy, 1'b1);
    chk("R9 data", br_data, 32'h6);

    // R10 branch blocked while station busy
    slot_can_issue = 2'b00;
    fetch(2'd2, 32'h7, 32'h8, 2'b01);
    step();
    slot_can_issue = 2'b11;
    step();
    chk("R10 blocked", iss_strobe, 2'b00);
    chk("R9 held", br_data, 32'h6);
    push(32'h7); push(32'h8);
    br_done = 1'b1;
    step();
    chk("R10 release", iss_strobe, 2'b11);
    chk("R10 newbr", br_data, 32'h7);
    chk("R10 busy", br_busy, 1'b1);

    // R9 done clears, done while idle ignored
    slot_can_issue = 2'b00;
    br_done = 1'b1;
    step();
    chk("R9 clear", br_busy, 1'b0);
    br_done = 1'b1;
    step();
    chk("R9 idle", br_busy, 1'b0);

    // R10 two branches: only older issues
    fetch(2'd2, 32'h9, 32'h10, 2'b11); push(32'h9); push(32'h10);
    step();
    slot_can_issue = 2'b11;
    step();
    chk("R10 onebr", iss_strobe, 2'b01);
    chk("R10 s0", slot_data0, 32'h10);
    chk("R10 bd", br_data, 32'h9);
    slot_can_issue = 2'b01;
    br_done = 1'b1;
    step();
    chk("R10 second", iss_strobe, 2'b01);
    chk("R10 bd2", br_data, 32'h10);

    // R10 non-branch issues while station busy
    slot_can_issue = 2'b00;
    fetch(2'd1, 32'h11, 32'h0, 2'b00); push(32'h11);
    step();
    slot_can_issue = 2'b01;
    step();
    chk("R10 pass", iss_strobe, 2'b01);
    chk("R10 stillbusy", br_busy, 1'b1);

    // R11 flush
    slot_can_issue = 2'b00;
    fetch(2'd3, 32'h12, 32'h13, 2'b00);
    step();
    chk("R7 cnt3", slot_valid, 2'b11);
    slot_can_issue = 2'b11;
    flush = 1'b1;
    fetch(2'd2, 32'h14, 32'h15, 2'b00);
    step();
    chk("R11 valid", slot_valid, 2'b00);
    chk("R11 strobe", iss_strobe, 2'b00);
    chk("R11 busy", br_busy, 1'b0);
    chk("R11 room", fetch_room, 2'd2);
    step();
    chk("R2 drained", exp_q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule